// File: doc/BRIEF.md
# 32 kHz Sync Counter Peripheral

This peripheral counts cycles of a slow 32768 Hz reference and lets software read the count over a simple read-only register bus. The reference arrives as a level that is asynchronous to the bus clock. A two-stage synchronizer brings it into the bus domain, and an edge detector turns each rising edge into one count. The count is zero when reset is released, so a read returns the number of reference ticks since the last reset.

Bus masters can read the counter as a 32-bit word or as two 16-bit halves. A narrow read of the lower half captures the upper half into a holding register. A narrow read at the +2 offset then returns that captured value, so the two halves always come from the same sample. A fixed identification word sits at offset 0x00 and the counter at offset 0x10. Any illegal access width, unknown offset or write produces a one-cycle error pulse.

Top module: `sctr_top`

## Requirements
- R1: Once reset is released, a word read of offset 0x10 returns 0 if the reference has not risen.
- R2: Each rising edge of `tickIn` that is held for at least one bus clock high and one low adds exactly one to the counter. The count never changes by more than one per clock.
- R3: A word read (`busSize` = 2'b10) of offset 0x00 returns 0x00000021 with no error.
- R4: A word read of offset 0x10 returns the current count, zero-extended to 32 bits.
- R5: A halfword read (`busSize` = 2'b01) with address bit 1 clear returns bits 15:0 of the addressed word in `rdData[15:0]`, with zeros above. It also stores bits 31:16 of that word in the holding register. No other access changes the holding register.
- R6: A halfword read with address bit 1 set returns the holding register in `rdData[15:0]`, at any offset and without an error.
- R7: A read with `busSize` of 2'b00 (byte) or 2'b11 returns data 0 with `rdValid` high, `errPulse` high and `errWidth` high.
- R8: A write (`busWrite` = 1) gives `errPulse` high, `errWidth` low and `rdValid` low. It changes neither the counter nor the holding register.
- R9: A word or low-halfword read at any offset other than 0x00 or 0x10 returns 0 with `errPulse` high and `errWidth` low. For a low-halfword read, it also loads 0 into the holding register.
- R10: The counter wraps from its all-ones value to 0 with no error.
- R11: Outputs appear exactly one clock after the strobe, for one cycle only. In a cycle that follows no strobe, `rdValid` and `errPulse` are low and `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | 32768 Hz reference level, asynchronous to `clk` |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write access, 0 = read access |
| busAddr | input | ADDR_W | Byte offset of the access |
| busSize | input | 2 | 00 byte, 01 halfword, 10 word, 11 illegal |
| rdData | output | 32 | Read data, valid with `rdValid` |
| rdValid | output | 1 | Read completion, one cycle after a read strobe |
| errPulse | output | 1 | One-cycle flag for an illegal access |
| errWidth | output | 1 | With `errPulse`: 1 = bad width, 0 = bad offset or write |

## Verification
The bound checker watches the following on every cycle:
- the silence of the outputs when there is no strobe;
- the error signalling for writes and illegal widths;
- the identification word;
- that the holding register changes only on a low-halfword read, and that a high-halfword read returns it;
- that the count steps by at most one per clock.

Whether the count equals the number of reference edges, whether split reads put together a coherent 32-bit value, and whether wrap-around happens can only be shown by the bench's scenarios. These need known tick sequences followed by reads.

// File: rtl/sctr_pkg.sv
package sctr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } accSize_e;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'b00,
    SRC_REV   = 2'b01,
    SRC_COUNT = 2'b10
  } regSrc_e;

  typedef struct packed {
    logic    rdEn;
    regSrc_e src;
    logic    halfLow;
    logic    halfHigh;
  } dpStrobes_t;

endpackage

// File: rtl/sctr_ctrl.sv
module sctr_ctrl
  import sctr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REV_OFS = '0,
  parameter logic [ADDR_W-1:0] CNT_OFS = ADDR_W'(16)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output dpStrobes_t        strb,
  output logic              rdValid,
  output logic              errPulse,
  output logic              errWidth
);

  logic     isRead;
  logic     isWrite;
  logic     hitRev;
  logic     hitCnt;
  logic     badWidth;
  logic     badReg;
  accSize_e sizeCode;
  regSrc_e  wordSrc;

  assign isRead   = busSel && !busWrite;
  assign isWrite  = busSel && busWrite;
  assign hitRev   = (busAddr == REV_OFS);
  assign hitCnt   = (busAddr == CNT_OFS);
  assign sizeCode = accSize_e'(busSize);

  // full-word source selected by exact offset match
  always_comb begin
    if (hitRev)      wordSrc = SRC_REV;
    else if (hitCnt) wordSrc = SRC_COUNT;
    else             wordSrc = SRC_ZERO;
  end

  always_comb begin
    strb     = '0;
    badWidth = 1'b0;
    badReg   = 1'b0;
    if (isRead) begin
      strb.rdEn = 1'b1;
      unique case (sizeCode)
        SZ_WORD: begin
          strb.src = wordSrc;
          badReg   = (wordSrc == SRC_ZERO);
        end
        SZ_HALF: begin
          if (busAddr[1]) begin
            strb.halfHigh = 1'b1;
          end else begin
            strb.halfLow = 1'b1;
            strb.src     = wordSrc;
            badReg       = (wordSrc == SRC_ZERO);
          end
        end
        default: badWidth = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      errPulse <= 1'b0;
      errWidth <= 1'b0;
    end else begin
      rdValid  <= isRead;
      errPulse <= badWidth || badReg || isWrite;
      errWidth <= badWidth;
    end
  end

endmodule

// File: rtl/sctr_datapath.sv
module sctr_datapath
  import sctr_pkg::*;
#(
  parameter int          CNT_W       = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] REV_ID      = 32'h21
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  dpStrobes_t       strb,
  output logic [31:0]      rdData,
  output logic [CNT_W-1:0] countVal,
  output logic [15:0]      holdVal
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   tickPrev;
  logic                   tickEdge;
  logic [31:0]            selVal;

  // reference synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES < 2) begin : g_bad_depth
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
      tickPrev  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_MSB-1:0], tickIn};
      tickPrev  <= syncChain[SYNC_MSB];
    end
  end

  assign tickEdge = syncChain[SYNC_MSB] && !tickPrev;

  // free-running counter, natural wrap
  always_ff @(posedge clk) begin
    if (!rstN)         countVal <= '0;
    else if (tickEdge) countVal <= countVal + 1'b1;
  end

  always_comb begin
    unique case (strb.src)
      SRC_REV:   selVal = REV_ID;
      SRC_COUNT: selVal = 32'(countVal);
      default:   selVal = '0;
    endcase
  end

  // read data register and halfword holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      holdVal <= '0;
    end else begin
      rdData <= '0;
      if (strb.rdEn) begin
        if (strb.halfHigh) begin
          rdData <= {16'h0, holdVal};
        end else if (strb.halfLow) begin
          rdData  <= {16'h0, selVal[15:0]};
          holdVal <= selVal[31:16];
        end else begin
          rdData <= selVal;
        end
      end
    end
  end

endmodule

// File: rtl/sctr_top.sv
module sctr_top
  import sctr_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          CNT_W       = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] REV_ID      = 32'h21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              errPulse,
  output logic              errWidth
);

  localparam logic [ADDR_W-1:0] REV_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CNT_OFS = ADDR_W'(16);

  dpStrobes_t       strb;
  logic [CNT_W-1:0] countVal;
  logic [15:0]      holdVal;

  sctr_ctrl #(
    .ADDR_W (ADDR_W),
    .REV_OFS(REV_OFS),
    .CNT_OFS(CNT_OFS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busSize (busSize),
    .strb    (strb),
    .rdValid (rdValid),
    .errPulse(errPulse),
    .errWidth(errWidth)
  );

  sctr_datapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .REV_ID     (REV_ID)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tickIn  (tickIn),
    .strb    (strb),
    .rdData  (rdData),
    .countVal(countVal),
    .holdVal (holdVal)
  );

endmodule

// File: rtl/sctr_checker.sv
module sctr_checker #(
  parameter int          ADDR_W = 8,
  parameter int          CNT_W  = 32,
  parameter logic [31:0] REV_ID = 32'h21
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic [31:0]       rdData,
  input logic              rdValid,
  input logic              errPulse,
  input logic              errWidth,
  input logic [CNT_W-1:0]  countVal,
  input logic [15:0]       holdVal
);

  logic rdStb;
  logic halfLowRd;
  logic halfHighRd;
  logic narrowBad;

  assign rdStb      = busSel && !busWrite;
  assign halfLowRd  = rdStb && (busSize == 2'b01) && !busAddr[1];
  assign halfHighRd = rdStb && (busSize == 2'b01) && busAddr[1];
  assign narrowBad  = rdStb && (busSize == 2'b00 || busSize == 2'b11);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> (!rdValid && !errPulse && rdData == 32'h0));

  // R8
  write_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite) |=> (errPulse && !errWidth && !rdValid));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !halfLowRd |=> $stable(holdVal));

  // R6
  half_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    halfHighRd |=> (rdData == {16'h0, $past(holdVal)} && !errPulse && rdValid));

  // R7
  bad_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    narrowBad |=> (errPulse && errWidth && rdValid && rdData == 32'h0));

  // R3
  rev_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && busSize == 2'b10 && busAddr == '0) |=> (rdData == REV_ID && !errPulse));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (countVal == $past(countVal) || countVal == CNT_W'($past(countVal) + 1'b1)));

endmodule

bind sctr_top sctr_checker #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W),
  .REV_ID(REV_ID)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busSize (busSize),
  .rdData  (rdData),
  .rdValid (rdValid),
  .errPulse(errPulse),
  .errWidth(errWidth),
  .countVal(countVal),
  .holdVal (holdVal)
);

// File: tb/sctr_top_tb.sv
module sctr_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 16;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [1:0]  size;
    logic [31:0] expData;
    logic        expValid;
    logic        expErr;
    logic        expWidth;
    logic [3:0]  req;
  } vec_t;

  // counter holds 0x00010005 while the table runs
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 2'b10, 32'h00000021, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b0, 8'h10, 2'b10, 32'h00010005, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 8'h10, 2'b01, 32'h00000005, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 latch 0001
    '{1'b0, 8'h12, 2'b01, 32'h00000001, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b0, 8'h02, 2'b01, 32'h00000001, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 any offset
    '{1'b0, 8'h10, 2'b00, 32'h00000000, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 byte
    '{1'b0, 8'h10, 2'b11, 32'h00000000, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 code 11
    '{1'b1, 8'h10, 2'b10, 32'h00000000, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 write
    '{1'b0, 8'h12, 2'b01, 32'h00000001, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 hold kept
    '{1'b0, 8'h04, 2'b10, 32'h00000000, 1'b1, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, 8'h12, 2'b10, 32'h00000000, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 misaligned word
    '{1'b0, 8'h00, 2'b01, 32'h00000021, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 latch 0000
    '{1'b0, 8'h02, 2'b01, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b0, 8'h10, 2'b01, 32'h00000005, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 latch 0001
    '{1'b0, 8'h08, 2'b01, 32'h00000000, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 latch 0000
    '{1'b0, 8'h12, 2'b01, 32'h00000000, 1'b1, 1'b0, 1'b0, 4'd9}   // R9 hold cleared
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        tickWrap = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] rdData, wRdData;
  logic        rdValid, errPulse, errWidth;
  logic        wRdValid, wErrPulse, wErrWidth;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sctr_top u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize),
    .rdData(rdData), .rdValid(rdValid), .errPulse(errPulse), .errWidth(errWidth)
  );

  // narrow counter instance for the wrap case
  sctr_top #(.CNT_W(4)) u_wrap (
    .clk(clk), .rstN(rstN), .tickIn(tickWrap),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize),
    .rdData(wRdData), .rdValid(wRdValid), .errPulse(wErrPulse), .errWidth(wErrWidth)
  );

  task automatic check(input int req, input logic [34:0] act, input logic [34:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d: got valid/err/width/data %h expected %h", req, act, exp);
    end
  endtask

  // one strobe cycle; returns at the negedge after the capturing edge
  task automatic access(input logic wr, input logic [7:0] a, input logic [1:0] sz);
    busSel   = 1'b1;
    busWrite = wr;
    busAddr  = a;
    busSize  = sz;
    @(negedge clk);
    busSel   = 1'b0;
    busWrite = 1'b0;
  endtask

  task automatic pulseTicks(input int n, input bit wrapSide);
    for (int i = 0; i < n; i++) begin
      if (wrapSide) tickWrap = 1'b1; else tickIn = 1'b1;
      @(negedge clk);
      if (wrapSide) tickWrap = 1'b0; else tickIn = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got no completion expected finish within %0d cycles", WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state: quiet outputs
    check(11, {rdValid, errPulse, errWidth, rdData}, 35'h0);

    // R1 count is zero after reset
    access(1'b0, 8'h10, 2'b10);
    check(1, {rdValid, errPulse, errWidth, rdData}, {3'b100, 32'h0});
    // R11 one cycle later the outputs are quiet again
    @(negedge clk);
    check(11, {rdValid, errPulse, errWidth, rdData}, 35'h0);

    // R2 five edges
    pulseTicks(5, 1'b0);
    access(1'b0, 8'h10, 2'b10);
    check(2, {rdValid, errPulse, errWidth, rdData}, {3'b100, 32'h5});

    // R2 cross into the upper half
    pulseTicks(65536, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      access(VECS[v].wr, VECS[v].addr, VECS[v].size);
      check(int'(VECS[v].req), {rdValid, errPulse, errWidth, rdData},
            {VECS[v].expValid, VECS[v].expErr, VECS[v].expWidth, VECS[v].expData});
    end

    // R8 write did not disturb the count
    access(1'b1, 8'h10, 2'b10);
    access(1'b0, 8'h10, 2'b10);
    check(8, {rdValid, errPulse, errWidth, rdData}, {3'b100, 32'h00010005});

    // R10 4-bit counter wraps after 16 edges
    pulseTicks(17, 1'b1);
    access(1'b0, 8'h10, 2'b10);
    check(10, {wRdValid, wErrPulse, wErrWidth, wRdData}, {3'b100, 32'h1});
    // R4 main counter untouched by the other reference
    check(4, {rdValid, errPulse, errWidth, rdData}, {3'b100, 32'h00010005});

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule